// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block takes the place of an ordinary pipeline register on a synchronous elastic channel. Each side of the stage carries a data word, a forward `valid` bit and a backward `stop` bit. A token moves across an interface only in a cycle where `valid` is high and `stop` is low. When `valid` and `stop` are both high, the sender must hold the same token until it is accepted.

The stage has a forward latency of one cycle and storage for two tokens. It is built from two half-buffer slots. The main slot drives the output. The auxiliary slot catches the token that arrives while a downstream stop is still travelling upstream. Because of this second slot, the upstream `in_stop` comes straight from a register. Chained stages therefore never form a combinational path through their stop signals.

Top module: `elastic_buffer2`

## Requirements
- R1: When reset is released, `out_valid` is low and `in_stop` is low, and the buffer holds no token.
- R2: A token accepted into an empty buffer appears on `out_valid`/`out_data` in the next cycle. `out_valid` is high exactly when the buffer holds at least one token.
- R3: If `out_valid` and `out_stop` are both high in a cycle (Retry), then in the next cycle `out_valid` is still high and `out_data` has not changed.
- R4: `in_stop` does not change within a cycle when `out_stop` changes. A stall at the output reaches `in_stop` no earlier than the next clock edge.
- R5: `in_stop` is high exactly when both slots hold a token.
- R6: Tokens leave in the order they entered, each exactly once. An input token counts as taken only when `in_valid`=1 and `in_stop`=0, and an output token only when `out_valid`=1 and `out_stop`=0.
- R7: While `out_stop` is held high, the buffer accepts exactly two tokens and then holds `in_stop` high. The held token leaves once `out_stop` falls.
- R8: A cycle with `in_valid` low (Idle) adds no token, whatever `in_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream token present |
| in_data | input | DATA_W | Upstream token value |
| in_stop | output | 1 | Backpressure to upstream (registered) |
| out_valid | output | 1 | Downstream token present |
| out_data | output | DATA_W | Downstream token value |
| out_stop | input | 1 | Backpressure from downstream |

## Verification
A slot whose valid flag is set wrongly shows up at once at the ports, because `out_valid` and `in_stop` are read directly from the flags. A wrong flag gives a token count that disagrees with the reference, and the mismatch appears one cycle after the transfer that caused it. A wrong slot-select or load enable shows up as a lost, duplicated or reordered token on the next output transfer. It can also show up as `out_data` changing during a Retry in the cycle after the stall.

// File: rtl/elastic_pkg.sv
package elastic_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_XFER  = 2'd1,
        CH_RETRY = 2'd2
    } chan_state_t;

    function automatic chan_state_t chan_state(input logic valid, input logic stop);
        if (!valid)
            return CH_IDLE;
        else if (stop)
            return CH_RETRY;
        else
            return CH_XFER;
    endfunction

    localparam int unsigned NUM_SLOTS = 2;
    localparam int unsigned SLOT_MAIN = 0;
    localparam int unsigned SLOT_AUX  = 1;

endpackage

// File: rtl/eb_slot.sv
module eb_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              clear,
    input  logic [DATA_W-1:0] d,
    output logic              full,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            full <= 1'b0;
        else if (load)
            full <= 1'b1;
        else if (clear)
            full <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (load)
            q <= d;
    end
endmodule

// File: rtl/eb_ctrl.sv
module eb_ctrl
    import elastic_pkg::*;
(
    input  logic in_valid,
    input  logic out_stop,
    input  logic main_full,
    input  logic aux_full,
    output logic main_load,
    output logic main_from_aux,
    output logic main_clear,
    output logic aux_load,
    output logic aux_clear,
    output logic stop_up
);
    chan_state_t up_st, dn_st;
    logic main_free;

    always_comb begin
        stop_up   = aux_full;
        up_st     = chan_state(in_valid, stop_up);
        dn_st     = chan_state(main_full, out_stop);
        main_free = !main_full || (dn_st == CH_XFER);

        main_from_aux = aux_full;
        main_load     = main_free && (aux_full || (up_st == CH_XFER));
        main_clear    = main_free && !main_load;
        aux_load      = !main_free && (up_st == CH_XFER);
        aux_clear     = main_free && aux_full;
    end
endmodule

// File: rtl/elastic_buffer2.sv
module elastic_buffer2
    import elastic_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_stop,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_stop
);
    logic [NUM_SLOTS-1:0]             slot_full;
    logic [NUM_SLOTS-1:0]             slot_load;
    logic [NUM_SLOTS-1:0]             slot_clear;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_d;
    logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_q;
    logic                             main_from_aux;

    eb_ctrl u_ctrl (
        .in_valid      (in_valid),
        .out_stop      (out_stop),
        .main_full     (slot_full[SLOT_MAIN]),
        .aux_full      (slot_full[SLOT_AUX]),
        .main_load     (slot_load[SLOT_MAIN]),
        .main_from_aux (main_from_aux),
        .main_clear    (slot_clear[SLOT_MAIN]),
        .aux_load      (slot_load[SLOT_AUX]),
        .aux_clear     (slot_clear[SLOT_AUX]),
        .stop_up       (in_stop)
    );

    always_comb begin
        slot_d[SLOT_MAIN] = main_from_aux ? slot_q[SLOT_AUX] : in_data;
        slot_d[SLOT_AUX]  = in_data;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        eb_slot #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst   (rst),
            .load  (slot_load[g]),
            .clear (slot_clear[g]),
            .d     (slot_d[g]),
            .full  (slot_full[g]),
            .q     (slot_q[g])
        );
    end

    assign out_valid = slot_full[SLOT_MAIN];
    assign out_data  = slot_q[SLOT_MAIN];
endmodule

// File: rtl/eb_checker.sv
module eb_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic              in_stop,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_stop
);
    AST_RESET_EMPTY: assert property (@(posedge clk)
        rst |=> (!out_valid && !in_stop)); // R1

    AST_FWD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_stop && !out_valid) |=> (out_valid && out_data == $past(in_data))); // R2

    AST_RETRY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_stop) |=> (out_valid && $stable(out_data))); // R3

    AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(in_stop) |-> ($past(out_stop) && $past(out_valid) && $past(in_valid))); // R4

    AST_STOP_NEEDS_OUT: assert property (@(posedge clk) disable iff (rst)
        in_stop |-> out_valid); // R5

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (in_stop && !out_stop) |=> !in_stop); // R7
endmodule

bind elastic_buffer2 eb_checker #(.DATA_W(DATA_W)) u_eb_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_stop   (in_stop),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_stop  (out_stop)
);

// File: tb/test_elastic_buffer2.sv
module test_elastic_buffer2;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_stop;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_stop = 1'b0;

    int checks = 0;
    int failures = 0;
    int seed_dummy;

    logic [DATA_W-1:0] q_mem [0:3];
    int                cnt = 0;
    logic              prev_retry = 1'b0;
    logic [DATA_W-1:0] prev_out = '0;
    logic              src_hold = 1'b0;
    logic [DATA_W-1:0] src_tok = '0;

    always #4 clk = ~clk;

    elastic_buffer2 #(.DATA_W(DATA_W)) i_elastic_buffer2 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_stop(in_stop),
        .out_valid(out_valid), .out_data(out_data), .out_stop(out_stop)
    );

    function automatic logic exp_stop(input int n);
        return n == 2;
    endfunction

    function automatic logic exp_valid(input int n);
        return n > 0;
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_state();
        check(out_valid == exp_valid(cnt), "R2 out_valid vs held count", 32'(out_valid), 32'(exp_valid(cnt)));
        check(in_stop == exp_stop(cnt), "R5 in_stop vs two held", 32'(in_stop), 32'(exp_stop(cnt)));
        if (cnt > 0)
            check(out_data == q_mem[0], "R6 order of tokens", 32'(out_data), 32'(q_mem[0]));
        if (prev_retry) begin
            check(out_valid == 1'b1, "R3 valid held in retry", 32'(out_valid), 32'd1);
            check(out_data == prev_out, "R3 data held in retry", 32'(out_data), 32'(prev_out));
        end
    endtask

    task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic s);
        logic stop_before;
        logic ix, ox;
        check_state();
        stop_before = in_stop;
        in_valid = v;
        in_data  = d;
        out_stop = s;
        #1;
        check(in_stop == stop_before, "R4 in_stop unaffected by out_stop", 32'(in_stop), 32'(stop_before));
        ix = in_valid && !in_stop;
        ox = out_valid && !out_stop;
        if (ox) begin
            q_mem[0] = q_mem[1];
            q_mem[1] = q_mem[2];
            cnt--;
        end
        if (ix) begin
            q_mem[cnt] = in_data;
            cnt++;
        end
        prev_retry = out_valid && out_stop;
        prev_out   = out_data;
        src_hold   = in_valid && in_stop;
        src_tok    = in_data;
        @(negedge clk);
    endtask

    initial begin
        #1600000;
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5eed_0042);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'd0);
        check(in_stop == 1'b0, "R1 in_stop after reset", 32'(in_stop), 32'd0);

        // R8: idle cycles with garbage data add nothing
        step(1'b0, 16'hdead, 1'b0);
        step(1'b0, 16'hbeef, 1'b0);
        check(out_valid == 1'b0, "R8 idle adds no token", 32'(out_valid), 32'd0);

        // R2: single token, latency one
        step(1'b1, 16'h1111, 1'b0);
        check(out_valid == 1'b1 && out_data == 16'h1111, "R2 one-cycle latency", 32'(out_data), 32'h1111);
        step(1'b0, 16'h0, 1'b0);

        // R7: fill under stall
        step(1'b1, 16'hA001, 1'b1);
        step(1'b1, 16'hA002, 1'b1);
        check(in_stop == 1'b1, "R7 full after two under stall", 32'(in_stop), 32'd1);
        step(1'b1, 16'hA003, 1'b1);
        step(1'b1, 16'hA003, 1'b1);
        check(cnt == 2, "R7 third token refused", 32'(cnt), 32'd2);
        check(out_data == 16'hA001, "R7 oldest token held", 32'(out_data), 32'hA001);
        step(1'b1, 16'hA003, 1'b0);
        check(out_data == 16'hA002, "R7 drain order", 32'(out_data), 32'hA002);
        step(1'b1, 16'hA003, 1'b0);
        step(1'b0, 16'h0, 1'b0);
        step(1'b0, 16'h0, 1'b0);
        step(1'b0, 16'h0, 1'b0);
        check(cnt == 0 && out_valid == 1'b0, "R6 all drained", 32'(out_valid), 32'd0);

        // random phase: source obeys retry rule
        for (int i = 0; i < 4000; i++) begin
            logic v;
            logic [DATA_W-1:0] d;
            if (src_hold) begin
                v = 1'b1;
                d = src_tok;
            end else begin
                v = ($urandom % 100) < 65;
                d = DATA_W'($urandom);
            end
            step(v, d, ($urandom % 100) < 40);
        end
        for (int i = 0; i < 4; i++) step(1'b0, 16'h0, 1'b0);
        check(cnt == 0 && out_valid == 1'b0, "R6 empty at end", 32'(out_valid), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule